// File: doc/BRIEF.md
# Monitor Sense Line Sequencer

This block works out which kind of display is attached by exercising three open-drain sense lines, here called A, B and C. A monitor ties these lines to ground or to each other in a way that is fixed for its type. When the start strobe arrives, the sequencer first drives all three lines high for a short precharge interval. It then releases them and lets them settle. After that it pulls each line low in turn, one at a time. At the end of each settling interval it samples the undriven lines.

The samples are packed into an 11-bit sense code. The code is published only when the whole pattern has completed, and a one-cycle done pulse marks that moment. The code is left for the surrounding logic to translate into a display mode.

Each line has its own release bit and level bit towards the pad. The two settle intervals are parameters, so short counts can be used in simulation and long ones in silicon.

Top module: `sense_seq`

## Requirements
- R1: After reset the code output is 0, the done output is 0, and all lines are released (release bits 3'b111, level bits 3'b111). Until a start strobe arrives, nothing changes. All 3-bit ports use bit 2 for line A, bit 1 for line B and bit 0 for line C.
- R2: A start strobe sampled while idle begins the precharge phase one cycle later. In that phase all three lines are driven high (release 3'b000, level 3'b111) for exactly SHORT_WAIT cycles.
- R3: The float phase follows. All lines are released (release 3'b111, level 3'b111) for exactly LONG_WAIT cycles. The levels read on its last cycle go into code bit 10 (A), bit 9 (B) and bit 8 (C).
- R4: The pull-A phase follows. Only A is driven low (release 3'b011, level 3'b011) for LONG_WAIT cycles. B is stored in code bit 5 and C in code bit 4. At no time is more than one line driven low.
- R5: The pull-B phase follows. Only B is driven low (release 3'b101, level 3'b101) for LONG_WAIT cycles. A is stored in code bit 3 and C in code bit 2.
- R6: The pull-C phase follows. Only C is driven low (release 3'b110, level 3'b110) for LONG_WAIT cycles. A is stored in code bit 1 and B in code bit 0.
- R7: Code bits 7:6 are always 0.
- R8: The done output is high for exactly one cycle, SHORT_WAIT + 4*LONG_WAIT cycles after the cycle in which the start strobe was sampled. The code output changes only in that cycle and holds its value until the next completion.
- R9: A start strobe that arrives while a sequence is running has no effect on the drive pattern, the phase lengths or the moment of completion.
- R10: Once a sequence completes, all lines are released (release 3'b111, level 3'b111).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; acted on only while idle |
| sense_i | input | 3 | Levels read back from lines A, B, C (bit 2 = A) |
| drv_hiz_o | output | 3 | Per-line release bit; 1 = driver off |
| drv_lvl_o | output | 3 | Per-line level driven when the driver is on |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | 11 | Packed sense code of the last completed sequence |

## Verification
The bench builds the sequencer with SHORT_WAIT = 3 and LONG_WAIT = 5. The two values differ, so a precharge that used the long count would show up as a shifted pattern, and so would a settle phase that used the short one. With these counts a full pattern takes only 23 cycles, which lets the bench check every phase cycle by cycle against a behavioural model of the monitor wiring, for six distinct ground-and-bridge arrangements. The same short counts keep a mid-sequence start strobe well inside a phase, so the test that such a strobe is ignored can see a restarted pattern if one happens.

// File: rtl/sense_pkg.sv
package sense_pkg;

  localparam int CODE_W = 11;
  localparam int NLINE  = 3;
  localparam int LN_A   = 2;
  localparam int LN_B   = 1;
  localparam int LN_C   = 0;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CHARGE,
    PH_FLOAT,
    PH_PULL_A,
    PH_PULL_B,
    PH_PULL_C
  } phase_t;

  typedef struct packed {
    logic [NLINE-1:0] hiz;
    logic [NLINE-1:0] lvl;
  } drive_t;

  // Pad pattern for each phase: released lines sit at level 1.
  function automatic drive_t drive_for(phase_t ph);
    drive_t d;
    d.hiz = '1;
    d.lvl = '1;
    case (ph)
      PH_CHARGE: d.hiz = '0;
      PH_PULL_A: begin d.hiz[LN_A] = 1'b0; d.lvl[LN_A] = 1'b0; end
      PH_PULL_B: begin d.hiz[LN_B] = 1'b0; d.lvl[LN_B] = 1'b0; end
      PH_PULL_C: begin d.hiz[LN_C] = 1'b0; d.lvl[LN_C] = 1'b0; end
      default: ;
    endcase
    return d;
  endfunction

  // Fold the readings of one phase into the accumulated code.
  function automatic logic [CODE_W-1:0] merge_sample(phase_t ph,
                                                     logic [CODE_W-1:0] acc,
                                                     logic [NLINE-1:0] s);
    logic [CODE_W-1:0] r;
    r = acc;
    case (ph)
      PH_FLOAT:  r[10:8] = {s[LN_A], s[LN_B], s[LN_C]};
      PH_PULL_A: r[5:4]  = {s[LN_B], s[LN_C]};
      PH_PULL_B: r[3:2]  = {s[LN_A], s[LN_C]};
      PH_PULL_C: r[1:0]  = {s[LN_A], s[LN_B]};
      default: ;
    endcase
    r[7:6] = 2'b00;
    return r;
  endfunction

  function automatic phase_t next_phase(phase_t ph);
    phase_t n;
    case (ph)
      PH_CHARGE: n = PH_FLOAT;
      PH_FLOAT:  n = PH_PULL_A;
      PH_PULL_A: n = PH_PULL_B;
      PH_PULL_B: n = PH_PULL_C;
      default:   n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sense_timer.sv
module sense_timer #(
  parameter int SHORT_WAIT = 200,
  parameter int LONG_WAIT  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic short_sel,
  output logic last
);

  localparam int MAXW = (SHORT_WAIT > LONG_WAIT) ? SHORT_WAIT : LONG_WAIT;
  localparam int CW   = $clog2(MAXW + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit_m1;

  assign limit_m1 = short_sel ? CW'(SHORT_WAIT - 1) : CW'(LONG_WAIT - 1);
  assign last     = run && (cnt_q == limit_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || last)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit_m1)); // R3

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/sense_drive.sv
module sense_drive import sense_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase_nxt,
  output logic [NLINE-1:0] hiz,
  output logic [NLINE-1:0] lvl
);

  drive_t drv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) drv_q <= '{hiz: '1, lvl: '1};
    else        drv_q <= drive_for(phase_nxt);
  end

  assign hiz = drv_q.hiz;
  assign lvl = drv_q.lvl;

  AST_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~hiz & ~lvl) <= 1); // R4

endmodule

// File: rtl/sense_packer.sv
module sense_packer import sense_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              commit,
  input  phase_t            phase,
  input  logic [NLINE-1:0]  lines,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W-1:0] acc_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] merged;

  assign merged = merge_sample(phase, acc_q, lines);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      code_q <= '0;
    end else begin
      if (clear)       acc_q <= '0;
      else if (sample) acc_q <= merged;
      if (commit)      code_q <= merged;
    end
  end

  assign code = code_q;

  AST_COMMIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $past(commit)); // R8

endmodule

// File: rtl/sense_seq.sv
module sense_seq #(
  parameter int SHORT_WAIT = 200,
  parameter int LONG_WAIT  = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [2:0]  sense_i,
  output logic [2:0]  drv_hiz_o,
  output logic [2:0]  drv_lvl_o,
  output logic        done_o,
  output logic [10:0] code_o
);
  import sense_pkg::*;

  phase_t state_q, state_d;
  logic   busy, launch, phase_end, finish, done_q;

  assign busy   = (state_q != PH_IDLE);
  assign launch = !busy && start_i;
  assign finish = (state_q == PH_PULL_C) && phase_end;

  always_comb begin
    state_d = state_q;
    if (launch)         state_d = PH_CHARGE;
    else if (phase_end) state_d = next_phase(state_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  assign done_o = done_q;

  sense_timer #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .short_sel (state_q == PH_CHARGE),
    .last      (phase_end)
  );

  sense_drive i_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_nxt (state_d),
    .hiz       (drv_hiz_o),
    .lvl       (drv_lvl_o)
  );

  sense_packer i_packer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (launch),
    .sample (phase_end),
    .commit (finish),
    .phase  (state_q),
    .lines  (sense_i),
    .code   (code_o)
  );

  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !phase_end) |=> (state_q == $past(state_q))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state_q == PH_IDLE)); // R10

  AST_CHARGE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_CHARGE) |-> (drv_hiz_o == 3'b000 && drv_lvl_o == 3'b111)); // R2

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_IDLE) |-> (drv_hiz_o == 3'b111)); // R10

endmodule

// File: tb/test_sense_seq.sv
`timescale 1ns/1ps
module test_sense_seq;

  localparam int SH    = 3;
  localparam int LG    = 5;
  localparam int TOTAL = SH + 4 * LG;
  localparam int NVEC  = 6;

  // {ground A,B,C ; bridge AB,AC,BC ; expected code}
  localparam logic [16:0] VEC [NVEC] = '{
    {3'b000, 3'b000, 11'h73F},
    {3'b000, 3'b100, 11'h717},
    {3'b100, 3'b000, 11'h335},
    {3'b000, 3'b011, 11'h728},
    {3'b111, 3'b000, 11'h000},
    {3'b001, 3'b100, 11'h603}
  };

  localparam logic [2:0] EXP_HIZ [5] = '{3'b000, 3'b111, 3'b011, 3'b101, 3'b110};
  localparam logic [2:0] EXP_LVL [5] = '{3'b111, 3'b111, 3'b011, 3'b101, 3'b110};
  localparam string      PH_REQ  [5] = '{"R2", "R3", "R4", "R5", "R6"};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  sense_i;
  logic [2:0]  drv_hiz_o, drv_lvl_o;
  logic        done_o;
  logic [10:0] code_o;
  logic [2:0]  gnd, link;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sense_seq #(.SHORT_WAIT(SH), .LONG_WAIT(LG)) i_sense_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .sense_i   (sense_i),
    .drv_hiz_o (drv_hiz_o),
    .drv_lvl_o (drv_lvl_o),
    .done_o    (done_o),
    .code_o    (code_o)
  );

  // Monitor model: pull-ups, grounded lines, bridges between lines.
  logic low_a, low_b, low_c;
  always_comb begin
    low_a = !drv_hiz_o[2] && !drv_lvl_o[2];
    low_b = !drv_hiz_o[1] && !drv_lvl_o[1];
    low_c = !drv_hiz_o[0] && !drv_lvl_o[0];
    sense_i[2] = !drv_hiz_o[2] ? drv_lvl_o[2] :
                 !(gnd[2] || (link[2] && low_b) || (link[1] && low_c));
    sense_i[1] = !drv_hiz_o[1] ? drv_lvl_o[1] :
                 !(gnd[1] || (link[2] && low_a) || (link[0] && low_c));
    sense_i[0] = !drv_hiz_o[0] ? drv_lvl_o[0] :
                 !(gnd[0] || (link[1] && low_a) || (link[0] && low_b));
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one sequence; inject >= 0 raises start during that busy cycle.
  task automatic run_seq(input logic [10:0] exp, input int inject);
    int bad [5];
    int bad_hold;
    logic [10:0] prev;
    for (int p = 0; p < 5; p++) bad[p] = 0;
    bad_hold = 0;
    prev = code_o;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int i = 0; i < TOTAL; i++) begin
      int p;
      p = (i < SH) ? 0 : 1 + (i - SH) / LG;
      if (drv_hiz_o !== EXP_HIZ[p] || drv_lvl_o !== EXP_LVL[p]) bad[p]++;
      if (done_o !== 1'b0 || code_o !== prev) bad_hold++;
      start_i = (i == inject);
      @(negedge clk);
    end
    start_i = 1'b0;
    for (int p = 0; p < 5; p++) chk(PH_REQ[p], bad[p], 0);
    chk("R8 code held and no early done", bad_hold, 0);
    chk("R8 done at end", done_o, 1'b1);
    chk("R3 bits 10:8", code_o[10:8], exp[10:8]);
    chk("R4 bits 5:4",  code_o[5:4],  exp[5:4]);
    chk("R5 bits 3:2",  code_o[3:2],  exp[3:2]);
    chk("R6 bits 1:0",  code_o[1:0],  exp[1:0]);
    chk("R7 bits 7:6",  code_o[7:6],  2'b00);
    chk("R10 release",  {drv_hiz_o, drv_lvl_o}, 6'b111111);
    @(negedge clk);
    chk("R8 single pulse", done_o, 1'b0);
    chk("R8 code holds", code_o, exp);
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    gnd     = 3'b000;
    link    = 3'b000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code", code_o, 11'h000);
    chk("R1 done", done_o, 1'b0);
    chk("R1 release", drv_hiz_o, 3'b111);
    chk("R1 level", drv_lvl_o, 3'b111);
    repeat (10) @(negedge clk);
    chk("R1 idle quiet", {done_o, drv_hiz_o, code_o}, {1'b0, 3'b111, 11'h000});

    for (int v = 0; v < NVEC; v++) begin
      gnd  = VEC[v][16:14];
      link = VEC[v][13:11];
      run_seq(VEC[v][10:0], -1);
      repeat (2) @(negedge clk);
    end

    // R9: start strobes while busy, mid float phase and on the final cycle
    gnd  = 3'b100;
    link = 3'b000;
    run_seq(11'h335, SH + 2);
    gnd  = 3'b000;
    link = 3'b011;
    run_seq(11'h728, TOTAL - 1);
    repeat (3) @(negedge clk);
    chk("R9 no restart after ignored strobe", {done_o, drv_hiz_o}, {1'b0, 3'b111});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule